// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits beside a first-level cache and hides the latency of a slower, pipelined next level for sequential reference patterns. When the cache misses it presents the line address here. If the address matches the head of one of the stream buffers, the buffered line is handed back with a one-cycle answer. If the line is still in flight, the answer waits for it. If no head matches, the least-recently-used buffer is taken over. It is restarted at the following line address and begins fetching the next lines into its own small FIFO. Prefetched lines live only in these FIFOs; the block has no path into the cache arrays.

Each buffer keeps a fixed number of slots. Every time a head is consumed, its slot is refilled with the line one FIFO-depth further along the stream. Line requests go to memory with a tag that names the buffer and the slot, so the memory may return them in any order and several may be outstanding at once. The number of buffers is a parameter, so several interleaved sequential streams can be followed at the same time. A buffer that is taken over while requests are still out marks those slots as stale and drops their late responses.

Top module: `sb_prefetch`

## Requirements
- R1: After reset no buffer holds a stream. Every lookup answers in its own cycle with hit low, and no memory request is raised before the first miss.
- R2: A lookup whose line address matches no buffer head completes in the same cycle (`lk_done`=1, `lk_hit`=0). It claims the victim buffer, which then requests lines addr+1 to addr+DEPTH. With no other traffic these go out in that order, with tags 0..DEPTH-1 when buffer 0 is claimed.
- R3: A lookup that matches a buffer head whose data is present completes with `lk_hit`=1 and `lk_data` equal to the data memory returned for that line. The head is popped, so the next head of that buffer is addr+1. When several heads match, the lowest-numbered buffer serves.
- R4: Popping a head refills the freed slot, and a memory request for line addr+DEPTH is issued.
- R5: A lookup that matches a head whose data has not yet returned holds `lk_done` low until the response arrives. It then completes as a hit with the right data.
- R6: A request tag is buffer_index*DEPTH + slot_index (`mreq_tag` = {buffer, slot}). Responses are routed by that tag alone, and any return order yields correct lookup data.
- R7: Claiming a buffer discards its old contents. Responses to requests issued for the old stream are dropped and never appear as `lk_data` of the new stream.
- R8: The victim is the buffer least recently touched, where a hit or a claim counts as a touch. Out of reset the buffers are claimed in the order 0, 1, 2, ...
- R9: With at least two buffers, two interleaved sequential miss streams each hit on every lookup after their own first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present; held until `lk_done` |
| lk_addr | input | LA_W | Line address of the cache miss |
| lk_done | output | 1 | Lookup completes at this clock edge |
| lk_hit | output | 1 | Completed lookup was served from a buffer |
| lk_data | output | DW | Line data on a hit, zero otherwise |
| mreq_valid | output | 1 | Line request to memory |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | LA_W | Requested line address |
| mreq_tag | output | TAG_W | {buffer index, slot index} |
| mrsp_valid | input | 1 | Memory response present (always accepted) |
| mrsp_tag | input | TAG_W | Tag of the returning request |
| mrsp_data | input | DW | Returned line data |

## Verification
The bench goes after a takeover while a long-latency memory still owes the old stream its lines. A design that forgets those slots would hand the new stream the old stream's data under the same tags. It stretches memory latency so that a lookup lands on a head whose line is still out. A block that answered early would return garbage, and one that never woke would hang. Interleaved streams and an eviction sequence check the least-recently-used choice, because a wrong victim turns an expected hit into a miss. Randomized out-of-order returns and back-pressure on requests check tag routing and the refill by DEPTH lines, since a wrong refill address shows up as a miss once a stream has run past its first DEPTH lines.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // index width that stays legal for a count of one
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // slot reached by stepping k places from the head of a circular FIFO
  function automatic int unsigned ring_step(input int unsigned hd, input int unsigned k,
                                            input int unsigned depth);
    return (hd + k) % depth;
  endfunction
endpackage

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int NBUF = 4,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_id,
  output logic [IW-1:0] victim
);
  logic [IW-1:0]   age_q [NBUF];
  logic [NBUF-1:0] oldest_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) age_q[i] <= IW'(NBUF - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < NBUF; i++) begin
        if (IW'(i) == touch_id)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_id]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NBUF; i++) begin
      oldest_v[i] = (age_q[i] == IW'(NBUF - 1));
      if (oldest_v[i]) victim = IW'(i);
    end
  end

  // R8: the ages stay a permutation, so exactly one buffer is the victim
  p_one_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_v) == 1);
  // R8: a touched buffer is the youngest afterwards
  p_touch_young_r8: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> age_q[$past(touch_id)] == '0);
endmodule

// File: rtl/sb_stream.sv
module sb_stream
  import sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LA_W  = 16,
  parameter int DW    = 32,
  parameter int EI_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [LA_W-1:0] alloc_base,
  input  logic            pop,
  input  logic            issue,
  input  logic            rsp_v,
  input  logic [EI_W-1:0] rsp_idx,
  input  logic [DW-1:0]   rsp_data,
  output logic            bvalid,
  output logic [LA_W-1:0] head_addr,
  output logic            head_avail,
  output logic [DW-1:0]   head_data,
  output logic            want,
  output logic [EI_W-1:0] want_idx,
  output logic [LA_W-1:0] want_addr
);
  logic [LA_W-1:0]  line_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] sent_q, avail_q, stale_q;
  logic [EI_W-1:0]  hd_q;
  logic             bval_q;
  // per-slot events this cycle
  logic [DEPTH-1:0] rsp_hit_v, iss_v;

  assign bvalid     = bval_q;
  assign head_addr  = line_q[hd_q];
  assign head_avail = bval_q && avail_q[hd_q];
  assign head_data  = data_q[hd_q];

  // oldest slot that still needs a request goes first
  always_comb begin
    int unsigned j;
    want     = 1'b0;
    want_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = ring_step(32'(hd_q), 32'(k), 32'(DEPTH));
      if (!want && bval_q && !sent_q[j] && !stale_q[j]) begin
        want     = 1'b1;
        want_idx = EI_W'(j);
      end
    end
    want_addr = line_q[want_idx];
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rsp_hit_v[i] = rsp_v && (rsp_idx == EI_W'(i));
      iss_v[i]     = issue && (want_idx == EI_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bval_q  <= 1'b0;
      hd_q    <= '0;
      sent_q  <= '0;
      avail_q <= '0;
      stale_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (alloc) begin
        bval_q <= 1'b1;
        hd_q   <= '0;
      end else if (pop) begin
        hd_q <= EI_W'(ring_step(32'(hd_q), 32'd1, 32'(DEPTH)));
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc) begin
          line_q[i]  <= alloc_base + LA_W'(i + 1);
          sent_q[i]  <= 1'b0;
          avail_q[i] <= 1'b0;
          // a request still owed (or leaving now) makes the slot stale
          stale_q[i] <= (sent_q[i] || iss_v[i] || stale_q[i]) && !avail_q[i] && !rsp_hit_v[i];
        end else if (pop && (hd_q == EI_W'(i))) begin
          line_q[i]  <= line_q[i] + LA_W'(DEPTH);
          sent_q[i]  <= 1'b0;
          avail_q[i] <= 1'b0;
        end else begin
          if (iss_v[i]) sent_q[i] <= 1'b1;
          if (rsp_hit_v[i]) begin
            if (stale_q[i]) stale_q[i] <= 1'b0;
            else begin
              avail_q[i] <= 1'b1;
              data_q[i]  <= rsp_data;
            end
          end
        end
      end
    end
  end

  // R3 / R5: a pop only happens on a head whose line is present
  p_pop_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_avail);
  // R2: a claimed buffer starts one line past the miss and waits for data
  p_alloc_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (bvalid && !head_avail && head_addr == $past(alloc_base) + LA_W'(1)));
  // R4: the popped slot is reloaded DEPTH lines further on
  p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !alloc) |=> line_q[$past(hd_q)] == $past(head_addr) + LA_W'(DEPTH));
  // R6: a response only returns to a slot that is owed one
  p_rsp_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v |-> ((sent_q[rsp_idx] && !avail_q[rsp_idx]) || stale_q[rsp_idx]));
  // R2: the arbiter only grants a slot that asked
  p_grant_asked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> want);
endmodule

// File: rtl/sb_prefetch.sv
module sb_prefetch
  import sb_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int DEPTH = 4,
  parameter int LA_W  = 16,
  parameter int DW    = 32,
  parameter int BI_W  = idx_bits(NBUF),
  parameter int EI_W  = idx_bits(DEPTH),
  parameter int TAG_W = BI_W + EI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [LA_W-1:0]  lk_addr,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [DW-1:0]    lk_data,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [LA_W-1:0]  mreq_addr,
  output logic [TAG_W-1:0] mreq_tag,
  input  logic             mrsp_valid,
  input  logic [TAG_W-1:0] mrsp_tag,
  input  logic [DW-1:0]    mrsp_data
);
  logic [NBUF-1:0] bvalid_v, head_avail_v, want_v, match_v;
  logic [NBUF-1:0] pop_v, alloc_v, issue_v, rspv_v;
  logic [LA_W-1:0] head_addr_a [NBUF];
  logic [LA_W-1:0] want_addr_a [NBUF];
  logic [DW-1:0]   head_data_a [NBUF];
  logic [EI_W-1:0] want_idx_a  [NBUF];

  logic            hit_any, head_ready;
  logic [BI_W-1:0] sel, gsel, victim, rsp_buf;
  logic [EI_W-1:0] rsp_idx;

  assign rsp_buf = mrsp_tag[TAG_W-1:EI_W];
  assign rsp_idx = mrsp_tag[EI_W-1:0];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    assign match_v[g] = bvalid_v[g] && (head_addr_a[g] == lk_addr);
    assign pop_v[g]   = lk_valid && hit_any && (sel == BI_W'(g)) && head_avail_v[g];
    assign alloc_v[g] = lk_valid && !hit_any && (victim == BI_W'(g));
    assign issue_v[g] = mreq_valid && mreq_ready && (gsel == BI_W'(g));
    assign rspv_v[g]  = mrsp_valid && (rsp_buf == BI_W'(g));

    sb_stream #(.DEPTH(DEPTH), .LA_W(LA_W), .DW(DW), .EI_W(EI_W)) u_str (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_v[g]),
      .alloc_base(lk_addr),
      .pop       (pop_v[g]),
      .issue     (issue_v[g]),
      .rsp_v     (rspv_v[g]),
      .rsp_idx   (rsp_idx),
      .rsp_data  (mrsp_data),
      .bvalid    (bvalid_v[g]),
      .head_addr (head_addr_a[g]),
      .head_avail(head_avail_v[g]),
      .head_data (head_data_a[g]),
      .want      (want_v[g]),
      .want_idx  (want_idx_a[g]),
      .want_addr (want_addr_a[g])
    );
  end

  // lowest-numbered matching head serves; lowest-numbered asker is granted
  always_comb begin
    hit_any = 1'b0;
    sel     = '0;
    gsel    = '0;
    for (int b = NBUF - 1; b >= 0; b--) begin
      if (match_v[b]) begin
        hit_any = 1'b1;
        sel     = BI_W'(b);
      end
      if (want_v[b]) gsel = BI_W'(b);
    end
  end

  assign head_ready = head_avail_v[sel];
  assign lk_done    = lk_valid && (!hit_any || head_ready);
  assign lk_hit     = lk_valid && hit_any && head_ready;
  assign lk_data    = lk_hit ? head_data_a[sel] : '0;

  assign mreq_valid = |want_v;
  assign mreq_addr  = want_addr_a[gsel];
  assign mreq_tag   = {gsel, want_idx_a[gsel]};

  sb_lru #(.NBUF(NBUF), .IW(BI_W)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .touch   ((|pop_v) || (|alloc_v)),
    .touch_id(hit_any ? sel : victim),
    .victim  (victim)
  );

  // R8: one lookup touches at most one buffer
  p_single_touch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_v, alloc_v}));
  // R1: no request before any buffer holds a stream
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_v == '0) |-> !mreq_valid);
  // R5: a stalled lookup that keeps its address is not answered as a miss
  p_stall_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_done) ##1 (lk_valid && $stable(lk_addr)) |-> hit_any);
endmodule

// File: tb/sim_sb_prefetch.sv
module sim_sb_prefetch;
  localparam int NBUF = 4, DEPTH = 4, LA_W = 16, DW = 32, TAG_W = 4;
  localparam int NSLOT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [LA_W-1:0] lk_addr = '0;
  logic lk_done, lk_hit;
  logic [DW-1:0] lk_data;
  logic mreq_valid, mreq_ready = 1'b0;
  logic [LA_W-1:0] mreq_addr;
  logic [TAG_W-1:0] mreq_tag;
  logic mrsp_valid = 1'b0;
  logic [TAG_W-1:0] mrsp_tag = '0;
  logic [DW-1:0] mrsp_data = '0;

  always #2 clk = ~clk;

  sb_prefetch #(.NBUF(NBUF), .DEPTH(DEPTH), .LA_W(LA_W), .DW(DW)) u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory contents seen by the bench: a fixed scramble of the line address
  function automatic logic [DW-1:0] mdata(input logic [LA_W-1:0] a);
    return {a ^ 16'hA5C3, 16'(a * 16'd7 + 16'd3)};
  endfunction

  // ---------------- memory model ----------------
  int lat_lo = 1, lat_hi = 6, rdy_pct = 80;
  bit             s_v   [NSLOT];
  int             s_cnt [NSLOT];
  logic [TAG_W-1:0] s_tag [NSLOT];
  logic [LA_W-1:0]  s_adr [NSLOT];
  logic [LA_W-1:0]  log_adr [4096];
  logic [TAG_W-1:0] log_tag [4096];
  int log_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int start, pick, fr;
      for (int i = 0; i < NSLOT; i++) if (s_v[i] && s_cnt[i] > 0) s_cnt[i]--;
      start = $urandom_range(NSLOT - 1);
      pick = -1;
      for (int k = 0; k < NSLOT; k++) begin
        int i;
        i = (start + k) % NSLOT;
        if (pick < 0 && s_v[i] && s_cnt[i] == 0) pick = i;
      end
      if (pick >= 0) begin
        mrsp_valid = 1'b1;
        mrsp_tag   = s_tag[pick];
        mrsp_data  = mdata(s_adr[pick]);
        s_v[pick]  = 1'b0;
      end else begin
        mrsp_valid = 1'b0;
      end
      mreq_ready = ($urandom_range(99) < rdy_pct);
      if (mreq_valid && mreq_ready) begin
        fr = -1;
        for (int i = 0; i < NSLOT; i++) if (fr < 0 && !s_v[i]) fr = i;
        if (fr >= 0) begin
          s_v[fr] = 1'b1; s_cnt[fr] = $urandom_range(lat_hi, lat_lo);
          s_tag[fr] = mreq_tag; s_adr[fr] = mreq_addr;
        end
        if (log_n < 4096) begin
          log_adr[log_n] = mreq_addr; log_tag[log_n] = mreq_tag; log_n++;
        end
      end
    end
  end

  function automatic bit seen_req(input logic [LA_W-1:0] a);
    for (int i = 0; i < log_n; i++) if (log_adr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // ---------------- reference model of buffer heads ----------------
  logic [LA_W-1:0] m_head [NBUF];
  bit m_v [NBUF];
  int m_use [NBUF];
  int m_t = 100;

  function automatic bit model_step(input logic [LA_W-1:0] a);
    int vb;
    for (int b = 0; b < NBUF; b++)
      if (m_v[b] && m_head[b] == a) begin
        m_head[b] = a + 1'b1; m_use[b] = m_t++; return 1'b1;
      end
    vb = 0;
    for (int b = 1; b < NBUF; b++) if (m_use[b] < m_use[vb]) vb = b;
    m_v[vb] = 1'b1; m_head[vb] = a + 1'b1; m_use[vb] = m_t++;
    return 1'b0;
  endfunction

  // ---------------- lookup driver ----------------
  task automatic look(input logic [LA_W-1:0] a, output bit hit, output logic [DW-1:0] d,
                      output int waited);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; waited = 0;
    forever begin
      #1;
      if (lk_done) break;
      waited++;
      if (waited > 400) break;
      @(negedge clk);
    end
    hit = lk_hit; d = lk_data;
    if (waited > 400) begin
      check(1'b0, "R5 lookup never completed", 0, 1);
      hit = 1'b0;
    end
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic step(input logic [LA_W-1:0] a, input string req, output bit hit, output int waited);
    bit exp;
    logic [DW-1:0] d;
    exp = model_step(a);
    look(a, hit, d, waited);
    check(hit == exp, {req, " hit/miss"}, hit, exp);
    if (hit) check(d == mdata(a), {req, " R3 R6 data"}, d, mdata(a));
    else     check(d == '0, {req, " R2 miss data"}, d, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit h;
    int w;
    logic [LA_W-1:0] nx [6];
    void'($urandom(32'h5EED1234));
    for (int b = 0; b < NBUF; b++) begin m_v[b] = 0; m_use[b] = b; m_head[b] = '0; end
    for (int i = 0; i < NSLOT; i++) s_v[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset
    begin
      bit quiet;
      quiet = 1;
      for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (mreq_valid || lk_done) quiet = 0; end
      check(quiet && log_n == 0, "R1 idle after reset", log_n, 0);
    end

    // R1 R2: first lookup misses, buffer 0 requests the next DEPTH lines in order
    rdy_pct = 100; lat_lo = 3; lat_hi = 3;
    step(16'h0100, "R1", h, w);
    idle(12);
    for (int k = 0; k < DEPTH; k++) begin
      check(log_adr[k] == 16'h0101 + 16'(k), "R2 request order", log_adr[k], 16'h0101 + k);
      check(log_tag[k] == TAG_W'(k), "R2 R6 request tag", log_tag[k], k);
    end

    // R3: head hits pop in sequence; R4: each pop refills DEPTH lines on
    for (int k = 1; k <= 3; k++) step(16'h0100 + 16'(k), "R3", h, w);
    idle(12);
    for (int k = 5; k <= 7; k++)
      check(seen_req(16'h0100 + 16'(k)), "R4 refill request", 0, 16'h0100 + k);
    step(16'h0104, "R4", h, w);
    step(16'h0105, "R4", h, w);
    check(h == 1'b1, "R4 refilled line hit", h, 1);

    // R9: two interleaved streams hit after their first misses
    rdy_pct = 80; lat_lo = 1; lat_hi = 6;
    step(16'h2000, "R9", h, w);
    step(16'h3000, "R9", h, w);
    for (int k = 1; k <= 10; k++) begin
      step(16'h2000 + 16'(k), "R9", h, w);
      check(h, "R9 stream A continuous hit", h, 1);
      step(16'h3000 + 16'(k), "R9", h, w);
      check(h, "R9 stream B continuous hit", h, 1);
    end

    // R5: lookup lands on a head whose line is still in flight
    lat_lo = 25; lat_hi = 30; rdy_pct = 100;
    step(16'h4000, "R5", h, w);
    step(16'h4001, "R5", h, w);
    check(h && w >= 15, "R5 stalled until response", w, 15);

    // R7 R8: fill all buffers, then take over the oldest while its lines are owed
    lat_lo = 20; lat_hi = 30;
    for (int b = 0; b < NBUF; b++) step(16'h5000 + 16'(b) * 16'h1000, "R8", h, w);
    step(16'h9000, "R7", h, w);
    for (int k = 1; k <= DEPTH + 2; k++) begin
      step(16'h9000 + 16'(k), "R7", h, w);
      check(h, "R7 new stream hit after takeover", h, 1);
    end
    step(16'h5001, "R8", h, w);
    check(!h, "R8 evicted stream misses", h, 0);

    // R6 and the rest: random interleaved streams, out-of-order returns, back-pressure
    lat_lo = 1; lat_hi = 9; rdy_pct = 70;
    for (int s = 0; s < 6; s++) nx[s] = 16'hA000 + 16'(s) * 16'h0800;
    for (int n = 0; n < 500; n++) begin
      int s;
      s = $urandom_range(5);
      if ($urandom_range(99) < 8) nx[s] = 16'hA000 + 16'(s) * 16'h0800 + 16'($urandom_range(255)) * 16'h4;
      step(nx[s], "R6", h, w);
      nx[s] = nx[s] + 1'b1;
    end

    idle(40);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule